// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose branches and jumps are settled in decode. It is purely combinational. Each cycle it looks at the source register numbers held in decode and execute, and at the destination number, write-enable and load flag of the instructions in execute, memory and writeback. From these it chooses where each execute-stage ALU operand and each decode-stage comparator operand comes from. It also decides whether the pipeline must stall and whether a taken control transfer must flush the one instruction fetched behind it.

The unit holds its own decode-stage branch resolver. The resolver compares the two forwarded operands according to the control kind and reports a redirect. When a stall is raised in the same cycle, the redirect is withheld, because the operands are not yet valid. The register file is taken to write before it reads within a cycle, so a writeback-stage producer never needs a path into decode.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the instruction in execute is a load (`ex_wen_i`=1, `ex_load_i`=1) and its nonzero destination equals `id_rs1_i` or `id_rs2_i`, both `hold_o` and `bubble_o` are 1.
- R2: Each execute operand select (`ex_sel_a_o` for `ex_rs1_i`, `ex_sel_b_o` for `ex_rs2_i`) is 2'b10 when the memory-stage destination matches, else 2'b01 when the writeback-stage destination matches, else 2'b00. The value 2'b11 never appears.
- R3: A match is ignored when the register number is 0 or the producer's write-enable is 0. No forward and no stall arise from such a match.
- R4: `id_ctl_i` codes 1, 2, 3 and 4 (equal, not-equal, signed less-than, signed greater-or-equal) compare the two decode operands. `redirect_o` is 1 exactly when the condition holds. Code 0 is a non-control instruction and never redirects.
- R5: Codes 5 (direct jump) and 6 (register jump) always redirect when no stall is raised.
- R6: `flush_o` is 1 exactly when `redirect_o` is 1.
- R7: When a stall and a taken transfer coincide, `hold_o`=1 and `flush_o`=`redirect_o`=0.
- R8: A non-load instruction in execute whose nonzero destination is read by the decode-stage control instruction raises a stall. Codes 1 to 4 read both sources, code 6 reads only rs1, and code 5 reads none.
- R9: A load in the memory stage whose nonzero destination is read by the decode-stage control instruction raises a stall, and is never forwarded into decode.
- R10: Each decode operand select (`id_sel_a_o`, `id_sel_b_o`) is 2'b10 when a non-load memory-stage producer matches, else 2'b00. The comparison then uses `mem_result_i` in place of the register file data.
- R11: A writeback-stage producer matching a decode source causes neither a stall nor a decode forward. With no matches, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ctl_i | input | 3 | Control kind of the decode instruction (0 none, 1 eq, 2 ne, 3 lt, 4 ge, 5 jump, 6 register jump) |
| id_rs1_i | input | 5 | Decode source register 1 |
| id_rs2_i | input | 5 | Decode source register 2 |
| rf_rs1_data_i | input | 32 | Register file data for decode source 1 |
| rf_rs2_data_i | input | 32 | Register file data for decode source 2 |
| ex_rs1_i | input | 5 | Execute source register 1 |
| ex_rs2_i | input | 5 | Execute source register 2 |
| ex_rd_i | input | 5 | Execute destination register |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_result_i | input | 32 | Memory-stage ALU result |
| wb_rd_i | input | 5 | Writeback destination register |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| hold_o | output | 1 | Freeze PC and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |
| flush_o | output | 1 | Turn the fetch/decode contents into a no-op |
| redirect_o | output | 1 | Decode-stage control transfer is taken |
| ex_sel_a_o | output | 2 | Execute operand A source select |
| ex_sel_b_o | output | 2 | Execute operand B source select |
| id_sel_a_o | output | 2 | Decode comparator operand A source select |
| id_sel_b_o | output | 2 | Decode comparator operand B source select |

## Verification
The execute-forwarding patterns put the same register in both later stages, only in writeback, or at register 0 or with write-enable low. These separate correct priority from plain matching and from missing suppression. The branch patterns use values that are equal, and values that differ only in sign, such as -1 against 1. These distinguish signed from unsigned comparison and the four conditions from one another. Control instructions are then paired with an ALU producer in execute, a load in execute or memory, a producer in memory that must be forwarded, and a producer in writeback. These show the stall, the stall-over-flush precedence, and which operands each jump kind actually reads. A sweep over all 32 register numbers for the load-use case exposes any lost bit in the comparators and any missing zero-register guard.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WB  = 2'b01,
      SEL_MEM = 2'b10
   } fwd_sel_e;

   typedef enum logic [2:0] {
      FLOW_NONE = 3'd0,
      FLOW_EQ   = 3'd1,
      FLOW_NE   = 3'd2,
      FLOW_LT   = 3'd3,
      FLOW_GE   = 3'd4,
      FLOW_JMP  = 3'd5,
      FLOW_JREG = 3'd6
   } flow_e;

   localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/phc_ex_fwd.sv
module phc_ex_fwd
   import phc_pkg::*;
#(
   parameter int unsigned AW = 5
) (
   input  logic [NUM_SRC-1:0][AW-1:0] src_i,
   input  logic [AW-1:0]              mem_rd_i,
   input  logic                       mem_wen_i,
   input  logic [AW-1:0]              wb_rd_i,
   input  logic                       wb_wen_i,
   output logic [NUM_SRC-1:0][1:0]    sel_o
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic hit_mem;
      logic hit_wb;

      always_comb begin
         hit_mem = mem_wen_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == src_i[g]);
         hit_wb  = wb_wen_i  && (wb_rd_i  != ZERO_REG) && (wb_rd_i  == src_i[g]);
         if (hit_mem)     sel_o[g] = SEL_MEM;
         else if (hit_wb) sel_o[g] = SEL_WB;
         else             sel_o[g] = SEL_RF;
      end

      always_comb begin
         if (sel_o[g][1]) AST_EXSEL_LEGAL: assert (!sel_o[g][0]); // R2
         if (src_i[g] == ZERO_REG) AST_EXSEL_X0: assert (sel_o[g] == SEL_RF); // R3
      end
   end
endmodule

// File: rtl/phc_id_path.sv
module phc_id_path
   import phc_pkg::*;
#(
   parameter int unsigned AW   = 5,
   parameter int unsigned XLEN = 32
) (
   input  logic [NUM_SRC-1:0][AW-1:0]   rs_i,
   input  logic [NUM_SRC-1:0][XLEN-1:0] rf_data_i,
   input  logic [AW-1:0]                mem_rd_i,
   input  logic                         mem_wen_i,
   input  logic                         mem_load_i,
   input  logic [XLEN-1:0]              mem_result_i,
   output logic [NUM_SRC-1:0][1:0]      sel_o,
   output logic [NUM_SRC-1:0][XLEN-1:0] opnd_o
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic take_mem;

      always_comb begin
         take_mem  = mem_wen_i && !mem_load_i && (mem_rd_i != ZERO_REG)
                     && (mem_rd_i == rs_i[g]);
         sel_o[g]  = take_mem ? SEL_MEM : SEL_RF;
         opnd_o[g] = take_mem ? mem_result_i : rf_data_i[g];
      end

      always_comb begin
         if (mem_load_i) AST_IDSEL_NO_LOAD: assert (sel_o[g] != SEL_MEM); // R9
         if (sel_o[g] == SEL_RF) AST_IDSEL_RF_DATA: assert (opnd_o[g] == rf_data_i[g]); // R10
      end
   end
endmodule

// File: rtl/phc_resolve.sv
module phc_resolve
   import phc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [2:0]      ctl_i,
   input  logic [XLEN-1:0] opnd_a_i,
   input  logic [XLEN-1:0] opnd_b_i,
   output logic            taken_o
);
   logic same;
   logic less;

   always_comb begin
      same = (opnd_a_i == opnd_b_i);
      less = ($signed(opnd_a_i) < $signed(opnd_b_i));
      unique case (flow_e'(ctl_i))
         FLOW_EQ:             taken_o = same;
         FLOW_NE:             taken_o = !same;
         FLOW_LT:             taken_o = less;
         FLOW_GE:             taken_o = !less;
         FLOW_JMP, FLOW_JREG: taken_o = 1'b1;
         default:             taken_o = 1'b0;
      endcase
   end

   always_comb begin
      if (ctl_i == FLOW_NONE) AST_PLAIN_NOT_TAKEN: assert (!taken_o); // R4
      if (ctl_i == FLOW_EQ && opnd_a_i != opnd_b_i) AST_EQ_DIFF: assert (!taken_o); // R4
   end
endmodule

// File: rtl/phc_stall.sv
module phc_stall
   import phc_pkg::*;
#(
   parameter int unsigned AW = 5
) (
   input  logic [2:0]    ctl_i,
   input  logic [AW-1:0] rs1_i,
   input  logic [AW-1:0] rs2_i,
   input  logic [AW-1:0] ex_rd_i,
   input  logic          ex_wen_i,
   input  logic          ex_load_i,
   input  logic [AW-1:0] mem_rd_i,
   input  logic          mem_wen_i,
   input  logic          mem_load_i,
   input  logic          taken_i,
   output logic          hold_o,
   output logic          bubble_o,
   output logic          flush_o,
   output logic          redirect_o
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic reads_a;
   logic reads_b;
   logic ex_live;
   logic mem_live;
   logic load_use;
   logic ctl_ex;
   logic ctl_mem;
   logic stall;

   always_comb begin
      reads_a  = (ctl_i inside {FLOW_EQ, FLOW_NE, FLOW_LT, FLOW_GE, FLOW_JREG});
      reads_b  = (ctl_i inside {FLOW_EQ, FLOW_NE, FLOW_LT, FLOW_GE});
      ex_live  = ex_wen_i  && (ex_rd_i  != ZERO_REG);
      mem_live = mem_wen_i && (mem_rd_i != ZERO_REG);
      load_use = ex_live && ex_load_i && ((ex_rd_i == rs1_i) || (ex_rd_i == rs2_i));
      ctl_ex   = ex_live && !ex_load_i
                 && ((reads_a && ex_rd_i == rs1_i) || (reads_b && ex_rd_i == rs2_i));
      ctl_mem  = mem_live && mem_load_i
                 && ((reads_a && mem_rd_i == rs1_i) || (reads_b && mem_rd_i == rs2_i));
      stall      = load_use || ctl_ex || ctl_mem;
      hold_o     = stall;
      bubble_o   = stall;
      redirect_o = taken_i && !stall;
      flush_o    = redirect_o;
   end

   always_comb begin
      if (flush_o) AST_FLUSH_NOT_HELD: assert (!hold_o); // R7
      if (hold_o) AST_HELD_NO_REDIRECT: assert (!redirect_o); // R7
      if (ctl_i == FLOW_JMP && !ex_load_i) AST_JMP_NO_CTL_STALL: assert (!hold_o); // R8
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import phc_pkg::*;
#(
   parameter int unsigned AW   = 5,
   parameter int unsigned XLEN = 32
) (
   input  logic [2:0]      id_ctl_i,
   input  logic [AW-1:0]   id_rs1_i,
   input  logic [AW-1:0]   id_rs2_i,
   input  logic [XLEN-1:0] rf_rs1_data_i,
   input  logic [XLEN-1:0] rf_rs2_data_i,
   input  logic [AW-1:0]   ex_rs1_i,
   input  logic [AW-1:0]   ex_rs2_i,
   input  logic [AW-1:0]   ex_rd_i,
   input  logic            ex_wen_i,
   input  logic            ex_load_i,
   input  logic [AW-1:0]   mem_rd_i,
   input  logic            mem_wen_i,
   input  logic            mem_load_i,
   input  logic [XLEN-1:0] mem_result_i,
   input  logic [AW-1:0]   wb_rd_i,
   input  logic            wb_wen_i,
   output logic            hold_o,
   output logic            bubble_o,
   output logic            flush_o,
   output logic            redirect_o,
   output logic [1:0]      ex_sel_a_o,
   output logic [1:0]      ex_sel_b_o,
   output logic [1:0]      id_sel_a_o,
   output logic [1:0]      id_sel_b_o
);
   if (AW < 1) begin : g_bad_aw
      $error("pipe_hazard_ctl: AW must be at least 1");
   end
   if (XLEN < 2) begin : g_bad_xlen
      $error("pipe_hazard_ctl: XLEN must be at least 2");
   end

   logic [NUM_SRC-1:0][AW-1:0]   ex_src;
   logic [NUM_SRC-1:0][1:0]      ex_sel;
   logic [NUM_SRC-1:0][AW-1:0]   id_src;
   logic [NUM_SRC-1:0][XLEN-1:0] id_rf;
   logic [NUM_SRC-1:0][1:0]      id_sel;
   logic [NUM_SRC-1:0][XLEN-1:0] id_opnd;
   logic                         taken;

   assign ex_src = {ex_rs2_i, ex_rs1_i};
   assign id_src = {id_rs2_i, id_rs1_i};
   assign id_rf  = {rf_rs2_data_i, rf_rs1_data_i};

   phc_ex_fwd #(.AW(AW)) u_ex_fwd (
      .src_i     (ex_src),
      .mem_rd_i  (mem_rd_i),
      .mem_wen_i (mem_wen_i),
      .wb_rd_i   (wb_rd_i),
      .wb_wen_i  (wb_wen_i),
      .sel_o     (ex_sel)
   );

   phc_id_path #(.AW(AW), .XLEN(XLEN)) u_id_path (
      .rs_i         (id_src),
      .rf_data_i    (id_rf),
      .mem_rd_i     (mem_rd_i),
      .mem_wen_i    (mem_wen_i),
      .mem_load_i   (mem_load_i),
      .mem_result_i (mem_result_i),
      .sel_o        (id_sel),
      .opnd_o       (id_opnd)
   );

   phc_resolve #(.XLEN(XLEN)) u_resolve (
      .ctl_i    (id_ctl_i),
      .opnd_a_i (id_opnd[0]),
      .opnd_b_i (id_opnd[1]),
      .taken_o  (taken)
   );

   phc_stall #(.AW(AW)) u_stall (
      .ctl_i      (id_ctl_i),
      .rs1_i      (id_rs1_i),
      .rs2_i      (id_rs2_i),
      .ex_rd_i    (ex_rd_i),
      .ex_wen_i   (ex_wen_i),
      .ex_load_i  (ex_load_i),
      .mem_rd_i   (mem_rd_i),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .taken_i    (taken),
      .hold_o     (hold_o),
      .bubble_o   (bubble_o),
      .flush_o    (flush_o),
      .redirect_o (redirect_o)
   );

   assign ex_sel_a_o = ex_sel[0];
   assign ex_sel_b_o = ex_sel[1];
   assign id_sel_a_o = id_sel[0];
   assign id_sel_b_o = id_sel[1];

   always_comb begin
      if (hold_o) AST_HOLD_WITH_BUBBLE: assert (bubble_o); // R1
      if (redirect_o) AST_REDIRECT_FLUSHES: assert (flush_o); // R6
      if (id_ctl_i == 3'd5 && !hold_o) AST_JUMP_REDIRECTS: assert (redirect_o); // R5
   end
endmodule

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;
   localparam int unsigned AW   = 5;
   localparam int unsigned XLEN = 32;
   localparam int unsigned NV   = 20;

   typedef struct packed {
      logic [7:0]  req;
      logic [2:0]  ctl;
      logic [4:0]  rs1, rs2;
      logic [31:0] rf1, rf2;
      logic [4:0]  exs1, exs2, exrd;
      logic        exwe, exld;
      logic [4:0]  mrd;
      logic        mwe, mld;
      logic [31:0] mres;
      logic [4:0]  wrd;
      logic        wwe;
      logic        hold, redir;
      logic [1:0]  exa, exb, ida, idb;
   } vec_t;

   // req,ctl,rs1,rs2,rf1,rf2,exs1,exs2,exrd,exwe,exld,mrd,mwe,mld,mres,wrd,wwe,hold,redir,exa,exb,ida,idb
   localparam vec_t VECS [NV] = '{
      '{8'd11, 3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R11 idle
      '{8'd2,  3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd1, 5'd2, 5'd0,  1'b0,1'b0, 5'd1,  1'b1,1'b0, 32'h0,  5'd1, 1'b1, 1'b0,1'b0, 2'd2,2'd0,2'd0,2'd0}, // R2 newest wins
      '{8'd2,  3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd3, 5'd4, 5'd0,  1'b0,1'b0, 5'd5,  1'b1,1'b0, 32'h0,  5'd4, 1'b1, 1'b0,1'b0, 2'd0,2'd1,2'd0,2'd0}, // R2 writeback path
      '{8'd3,  3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b1,1'b0, 32'h0,  5'd0, 1'b1, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R3 x0
      '{8'd3,  3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd6, 5'd6, 5'd0,  1'b0,1'b0, 5'd6,  1'b0,1'b0, 32'h0,  5'd6, 1'b0, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R3 wen low
      '{8'd1,  3'd0, 5'd7,  5'd8,  32'h0, 32'h0, 5'd0, 5'd0, 5'd8,  1'b1,1'b1, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R1 load-use
      '{8'd3,  3'd0, 5'd0,  5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd0,  1'b1,1'b1, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R3 load to x0
      '{8'd4,  3'd1, 5'd9,  5'd10, 32'h5, 32'h5, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}, // R4 eq taken
      '{8'd4,  3'd2, 5'd9,  5'd10, 32'h5, 32'h5, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R4 ne not taken
      '{8'd4,  3'd3, 5'd9,  5'd10, 32'hFFFFFFFF, 32'h1, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 32'h0, 5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}, // R4 signed lt
      '{8'd4,  3'd4, 5'd9,  5'd10, 32'hFFFFFFFF, 32'h1, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 32'h0, 5'd0, 1'b0, 1'b0,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R4 signed ge
      '{8'd8,  3'd5, 5'd11, 5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd11, 1'b1,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}, // R8 jump reads nothing
      '{8'd5,  3'd6, 5'd12, 5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}, // R5 register jump
      '{8'd8,  3'd1, 5'd12, 5'd13, 32'h5, 32'h5, 5'd0, 5'd0, 5'd13, 1'b1,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R8 ALU feeds branch
      '{8'd9,  3'd2, 5'd14, 5'd0,  32'h1, 32'h2, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd14, 1'b1,1'b1, 32'h0,  5'd0, 1'b0, 1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R9 load in memory
      '{8'd10, 3'd1, 5'd15, 5'd16, 32'h0, 32'h22, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd15, 1'b1,1'b0, 32'h22, 5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd2,2'd0}, // R10 forward A
      '{8'd10, 3'd2, 5'd15, 5'd16, 32'h3, 32'h3, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd16, 1'b1,1'b0, 32'h4,  5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd2}, // R10 forward B flips
      '{8'd7,  3'd6, 5'd17, 5'd0,  32'h0, 32'h0, 5'd0, 5'd0, 5'd17, 1'b1,1'b1, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b1,1'b0, 2'd0,2'd0,2'd0,2'd0}, // R7 stall over jump
      '{8'd6,  3'd4, 5'd9,  5'd10, 32'h5, 32'h5, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd0, 1'b0, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}, // R6 ge equal flush
      '{8'd11, 3'd2, 5'd20, 5'd21, 32'h1, 32'h2, 5'd0, 5'd0, 5'd0,  1'b0,1'b0, 5'd0,  1'b0,1'b0, 32'h0,  5'd20, 1'b1, 1'b0,1'b1, 2'd0,2'd0,2'd0,2'd0}  // R11 writeback only
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [2:0]      id_ctl;
   logic [AW-1:0]   id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic [XLEN-1:0] rf1, rf2, mem_res;
   logic            ex_we, ex_ld, mem_we, mem_ld, wb_we;
   logic            hold, bubble, flush, redirect;
   logic [1:0]      exa, exb, ida, idb;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   pipe_hazard_ctl #(.AW(AW), .XLEN(XLEN)) u_pipe_hazard_ctl (
      .id_ctl_i(id_ctl), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
      .rf_rs1_data_i(rf1), .rf_rs2_data_i(rf2),
      .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
      .ex_wen_i(ex_we), .ex_load_i(ex_ld),
      .mem_rd_i(mem_rd), .mem_wen_i(mem_we), .mem_load_i(mem_ld),
      .mem_result_i(mem_res), .wb_rd_i(wb_rd), .wb_wen_i(wb_we),
      .hold_o(hold), .bubble_o(bubble), .flush_o(flush), .redirect_o(redirect),
      .ex_sel_a_o(exa), .ex_sel_b_o(exb), .id_sel_a_o(ida), .id_sel_b_o(idb)
   );

   task automatic check(input int req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      id_ctl = v.ctl;  id_rs1 = v.rs1;  id_rs2 = v.rs2;
      rf1 = v.rf1;     rf2 = v.rf2;
      ex_rs1 = v.exs1; ex_rs2 = v.exs2; ex_rd = v.exrd;
      ex_we = v.exwe;  ex_ld = v.exld;
      mem_rd = v.mrd;  mem_we = v.mwe;  mem_ld = v.mld; mem_res = v.mres;
      wb_rd = v.wrd;   wb_we = v.wwe;
   endtask

   initial begin
      apply('0);
      @(posedge clk);
      #1;
      // R11: quiet inputs give all-zero outputs
      check(11, "idle hold",     hold,     0);
      check(11, "idle redirect", redirect, 0);
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         #1 apply(VECS[i]);
         #1;
         check(VECS[i].req, $sformatf("v%0d hold", i),     hold,     VECS[i].hold);
         check(VECS[i].req, $sformatf("v%0d bubble", i),   bubble,   VECS[i].hold);  // R1
         check(VECS[i].req, $sformatf("v%0d redirect", i), redirect, VECS[i].redir);
         check(VECS[i].req, $sformatf("v%0d flush", i),    flush,    VECS[i].redir); // R6
         check(VECS[i].req, $sformatf("v%0d ex_sel_a", i), exa,      VECS[i].exa);
         check(VECS[i].req, $sformatf("v%0d ex_sel_b", i), exb,      VECS[i].exb);
         check(VECS[i].req, $sformatf("v%0d id_sel_a", i), ida,      VECS[i].ida);
         check(VECS[i].req, $sformatf("v%0d id_sel_b", i), idb,      VECS[i].idb);
      end
      // R1 and R3 sweep: load in execute against rs2 for every register number
      for (int r = 0; r < 32; r++) begin
         @(posedge clk);
         #1 apply('0);
         id_rs2 = 5'(r); ex_rd = 5'(r); ex_we = 1'b1; ex_ld = 1'b1;
         #1;
         check((r == 0) ? 3 : 1, $sformatf("sweep r%0d hold", r), hold, (r != 0) ? 1 : 0);
      end
      // R8: register jump reads only rs1, so an ALU producer of rs2 is no hazard
      @(posedge clk);
      #1 apply('0);
      id_ctl = 3'd6; id_rs1 = 5'd3; id_rs2 = 5'd9; ex_rd = 5'd9; ex_we = 1'b1;
      #1;
      check(8, "jreg rs2 ignored hold",     hold,     0);
      check(8, "jreg rs2 ignored redirect", redirect, 1);
      // R2 and R10: both later stages write the same register as both sources
      @(posedge clk);
      #1 apply('0);
      id_ctl = 3'd1; id_rs1 = 5'd4; id_rs2 = 5'd4; rf1 = 32'h1; rf2 = 32'h2;
      ex_rs1 = 5'd4; ex_rs2 = 5'd4;
      mem_rd = 5'd4; mem_we = 1'b1; mem_res = 32'h9; wb_rd = 5'd4; wb_we = 1'b1;
      #1;
      check(2,  "dual ex_sel_a",   exa,      2);
      check(2,  "dual ex_sel_b",   exb,      2);
      check(10, "dual id_sel_a",   ida,      2);
      check(10, "dual redirect",   redirect, 1);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule